// File: doc/BRIEF.md
# Ethernet Event and Mask Controller

This block gathers the per-frame event strobes of an Ethernet controller into an event register. Each bit stays set until software clears it. A mask register gates the event bits onto a single interrupt line. Software reads and clears the events through a small register port. Writing a one to an event bit clears it. The same port writes the mask.

The block also sequences two transmit-side actions so that neither cuts a frame short. The first is a graceful stop, which halts the transmitter after the current frame and reports completion. The second is a flow-control pause, requested after a control frame is received. Each action waits for the frame currently being sent to finish. When the transmitter is idle, the action takes effect at the next clock edge.

Top module: `eth_evt_ctrl`

## Requirements
- R1: After a synchronous reset, the event register and the mask register read as zero, and `irq`, `tx_halt` and `pause_req` are low.
- R2: Event bits sit at LSB-numbered positions 23 down to 16 of the 32-bit read word: 23 graceful-stop-done, 22 rx-control, 21 tx-control, 20 tx-error, 19 rx-frame, 18 busy (frame dropped, no buffer), 17 tx-buffer, 16 rx-buffer. All other bits read as zero.
- R3: Event bits are sticky. When `reg_wr` is high and `reg_sel`=0, each bit in 23:16 that is written as one is cleared and each bit written as zero is unchanged. An event arriving in the same cycle as its clear leaves the bit set.
- R4: When `reg_wr` is high and `reg_sel`=1, the mask is loaded from `reg_wdata[23:16]`. With `reg_sel`=1, `reg_rdata` returns the mask at the same positions. With `reg_sel`=0, it returns the event register.
- R5: `irq` is high exactly when some bit is set in both the event register and the mask register.
- R6: When `gstop_cmd` arrives while `tx_frame_active` is high, the graceful-stop-done bit stays clear until the first cycle in which `tx_frame_active` is low. The bit is set at the edge that ends that cycle.
- R7: When `gstop_cmd` arrives while `tx_frame_active` is low, the graceful-stop-done bit is set at that same clock edge.
- R8: `tx_halt` rises at the same edge as graceful-stop-done and stays high until `restart_cmd`. A `restart_cmd` also cancels a stop that is still waiting.
- R9: `rx_ctrl_stb` sets the rx-control bit and starts a pause only while `fc_enable` is high. Otherwise it has no effect.
- R10: A pause makes `pause_req` high for one cycle. The edge that raises it ends the first cycle, from the control frame onward, in which `tx_frame_active` is low.
- R11: Further control frames that arrive while a pause is waiting do not produce a second `pause_req` pulse.
- R12: Each of `txc_stb`, `txe_stb`, `rxf_stb`, `bsy_stb`, `txb_stb` and `rxb_stb` sets its own event bit at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_frame_active | input | 1 | Transmitter is sending a frame |
| gstop_cmd | input | 1 | Graceful-stop command pulse |
| restart_cmd | input | 1 | Restart-transmit command pulse |
| fc_enable | input | 1 | Flow-control enable |
| rx_ctrl_stb | input | 1 | Control frame received |
| txc_stb | input | 1 | Out-of-sequence frame sent |
| txe_stb | input | 1 | Transmit error |
| rxf_stb | input | 1 | Complete frame received |
| bsy_stb | input | 1 | Received frame dropped, no buffer |
| txb_stb | input | 1 | Buffer transmitted |
| rxb_stb | input | 1 | Partial-frame buffer received |
| reg_sel | input | 1 | 0 selects the event register, 1 selects the mask register |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Masked interrupt |
| tx_halt | output | 1 | Transmitter halted after a graceful stop |
| pause_req | output | 1 | One-cycle pause request |

## Verification
Every state change in this block is registered once. A strobe, a command or a write in one cycle therefore shows up on `reg_rdata`, `irq`, `tx_halt` and `pause_req` just after the next rising edge. The exception is an action deferred by an active frame. Such an action appears one edge after the first idle cycle. The bench drives inputs on the falling edge and samples all outputs one time unit after each rising edge. On every cycle it compares them with a reference that advances one step per edge. The directed sequences also hold `tx_frame_active` high for several cycles to show that nothing moves before the frame ends.

// File: rtl/eth_evt_pkg.sv
package eth_evt_pkg;

    localparam int WORD_W  = 32;
    localparam int EVT_W   = 8;
    localparam int EVT_LSB = 16;

    // Field order from MSB to LSB fixes the bit positions in the read word.
    typedef struct packed {
        logic gstop_done;
        logic rx_ctrl;
        logic tx_ctrl;
        logic tx_err;
        logic rx_frame;
        logic busy;
        logic tx_buf;
        logic rx_buf;
    } evt_t;

    function automatic logic [WORD_W-1:0] place_evt(input evt_t v);
        logic [WORD_W-1:0] w;
        w = '0;
        w[EVT_LSB +: EVT_W] = v;
        return w;
    endfunction

    function automatic evt_t pick_evt(input logic [WORD_W-1:0] w);
        return evt_t'(w[EVT_LSB +: EVT_W]);
    endfunction

endpackage

// File: rtl/eth_evt_stopseq.sv
module eth_evt_stopseq (
    input  logic clk,
    input  logic rst,
    input  logic tx_active,
    input  logic stop_cmd,
    input  logic restart_cmd,
    output logic stop_done,
    output logic tx_halt
);

    logic wait_q;
    logic want;

    assign want      = (stop_cmd | wait_q) & ~restart_cmd;
    assign stop_done = want & ~tx_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_q  <= 1'b0;
            tx_halt <= 1'b0;
        end else begin
            wait_q <= want & tx_active;
            if (restart_cmd)
                tx_halt <= 1'b0;
            else if (stop_done)
                tx_halt <= 1'b1;
        end
    end

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        stop_done |-> !tx_active);

    p_halt_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_halt && !restart_cmd) |=> tx_halt);

    p_halt_rise_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_halt) |-> $past(stop_done));

endmodule

// File: rtl/eth_evt_pauseseq.sv
module eth_evt_pauseseq (
    input  logic clk,
    input  logic rst,
    input  logic tx_active,
    input  logic ctrl_rx,
    input  logic fc_en,
    output logic ctrl_evt,
    output logic pause_req
);

    logic pend_q;
    logic need;

    assign ctrl_evt = ctrl_rx & fc_en;
    assign need     = pend_q | ctrl_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            pause_req <= 1'b0;
        end else begin
            pend_q    <= need & tx_active;
            pause_req <= need & ~tx_active;
        end
    end

    p_fc_gate_r9: assert property (@(posedge clk) disable iff (rst)
        ctrl_evt |-> fc_en);

    p_pause_idle_r10: assert property (@(posedge clk) disable iff (rst)
        pause_req |-> !$past(tx_active));

    p_single_r11: assert property (@(posedge clk) disable iff (rst)
        (pend_q && tx_active) |=> !pause_req);

endmodule

// File: rtl/eth_evt_regfile.sv
module eth_evt_regfile
    import eth_evt_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_t              set_vec,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int NB = EVT_W;

    evt_t ev_q, mask_q;
    logic [NB-1:0] clr_vec;
    logic unused_wbits;

    assign clr_vec      = (wr_en && !sel) ? wdata[EVT_LSB +: NB] : '0;
    assign unused_wbits = ^{wdata[DATA_W-1:EVT_LSB+NB], wdata[EVT_LSB-1:0]};

    for (genvar i = 0; i < NB; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                ev_q[i] <= 1'b0;
            else if (set_vec[i])
                ev_q[i] <= 1'b1;
            else if (clr_vec[i])
                ev_q[i] <= 1'b0;
        end

        p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
            (ev_q[i] && !clr_vec[i]) |=> ev_q[i]);

        p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> ev_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (wr_en && sel)
            mask_q <= pick_evt(wdata);
    end

    assign rdata = sel ? place_evt(mask_q) : place_evt(ev_q);
    assign irq   = |(ev_q & mask_q);

    p_mask_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

    p_irq_src_r5: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ev_q != '0));

endmodule

// File: rtl/eth_evt_ctrl.sv
module eth_evt_ctrl
    import eth_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_frame_active,
    input  logic              gstop_cmd,
    input  logic              restart_cmd,
    input  logic              fc_enable,
    input  logic              rx_ctrl_stb,
    input  logic              txc_stb,
    input  logic              txe_stb,
    input  logic              rxf_stb,
    input  logic              bsy_stb,
    input  logic              txb_stb,
    input  logic              rxb_stb,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    output logic              tx_halt,
    output logic              pause_req
);

    logic stop_done;
    logic ctrl_evt;
    evt_t set_vec;

    eth_evt_stopseq u_stop (
        .clk         (clk),
        .rst         (rst),
        .tx_active   (tx_frame_active),
        .stop_cmd    (gstop_cmd),
        .restart_cmd (restart_cmd),
        .stop_done   (stop_done),
        .tx_halt     (tx_halt)
    );

    eth_evt_pauseseq u_pause (
        .clk       (clk),
        .rst       (rst),
        .tx_active (tx_frame_active),
        .ctrl_rx   (rx_ctrl_stb),
        .fc_en     (fc_enable),
        .ctrl_evt  (ctrl_evt),
        .pause_req (pause_req)
    );

    always_comb begin
        set_vec            = '0;
        set_vec.gstop_done = stop_done;
        set_vec.rx_ctrl    = ctrl_evt;
        set_vec.tx_ctrl    = txc_stb;
        set_vec.tx_err     = txe_stb;
        set_vec.rx_frame   = rxf_stb;
        set_vec.busy       = bsy_stb;
        set_vec.tx_buf     = txb_stb;
        set_vec.rx_buf     = rxb_stb;
    end

    eth_evt_regfile #(.DATA_W(WORD_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .wr_en   (reg_wr),
        .sel     (reg_sel),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .irq     (irq)
    );

    p_reserved_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[WORD_W-1:EVT_LSB+EVT_W] == '0) && (reg_rdata[EVT_LSB-1:0] == '0));

    p_halt_with_event_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_halt) |-> reg_sel || reg_rdata[EVT_LSB+EVT_W-1]);

endmodule

// File: tb/sim_eth_evt_ctrl.sv
module sim_eth_evt_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic act = 1'b0, gstop = 1'b0, rstrt = 1'b0, fc = 1'b0, rxc = 1'b0;
    logic txc = 1'b0, txe = 1'b0, rxf = 1'b0, bsy = 1'b0, txb = 1'b0, rxb = 1'b0;
    logic sel = 1'b0, wr = 1'b0;
    logic [31:0] wd = '0;
    logic [31:0] rd;
    logic irq, halt, pause;

    int n_chk = 0, n_err = 0;

    // reference state
    logic [7:0] m_ev = '0, m_mask = '0;
    logic m_gp = 1'b0, m_halt = 1'b0, m_pp = 1'b0, m_pause = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eth_evt_ctrl u0 (
        .clk(clk), .rst(rst), .tx_frame_active(act), .gstop_cmd(gstop),
        .restart_cmd(rstrt), .fc_enable(fc), .rx_ctrl_stb(rxc),
        .txc_stb(txc), .txe_stb(txe), .rxf_stb(rxf), .bsy_stb(bsy),
        .txb_stb(txb), .rxb_stb(rxb), .reg_sel(sel), .reg_wr(wr),
        .reg_wdata(wd), .reg_rdata(rd), .irq(irq), .tx_halt(halt),
        .pause_req(pause)
    );

    function automatic logic [31:0] word_of(input logic [7:0] v);
        return {8'h00, v, 16'h0000};
    endfunction

    task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
        n_chk++;
        if (a !== e) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic summary;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Advance reference and design by one edge, then compare all outputs.
    task automatic tick;
        logic ok_rxc, gnow, want;
        logic [7:0] setv, clrv;
        ok_rxc = rxc & fc;
        want   = (gstop | m_gp) & ~rstrt;
        gnow   = want & ~act;
        setv   = {gnow, ok_rxc, txc, txe, rxf, bsy, txb, rxb};
        clrv   = (wr && !sel) ? wd[23:16] : 8'h00;
        m_gp    = want & act;
        m_halt  = rstrt ? 1'b0 : (m_halt | gnow);
        m_pause = (m_pp | ok_rxc) & ~act;
        m_pp    = (m_pp | ok_rxc) & act;
        m_ev    = (m_ev & ~clrv) | setv;
        if (wr && sel) m_mask = wd[23:16];
        @(posedge clk);
        #1;
        chk(sel ? "R4 mask read" : "R3 event read", rd, word_of(sel ? m_mask : m_ev));
        chk("R5 irq", {31'd0, irq}, {31'd0, |(m_ev & m_mask)});
        chk("R8 tx_halt", {31'd0, halt}, {31'd0, m_halt});
        chk("R10 pause_req", {31'd0, pause}, {31'd0, m_pause});
        @(negedge clk);
        {gstop, rstrt, rxc, txc, txe, rxf, bsy, txb, rxb, wr} = '0;
        wd = '0;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                n_chk++; n_err++;
                $display("FAIL watchdog expired");
                summary();
            end
        end
    end

    initial begin
        int pulses;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 event after reset", rd, 32'h0);
        sel = 1'b1; #1;
        chk("R1 mask after reset", rd, 32'h0);
        chk("R1 outputs after reset", {29'd0, irq, halt, pause}, 32'h0);
        sel = 1'b0;
        @(negedge clk);

        // R4/R2: mask write of all ones keeps only 23:16
        sel = 1'b1; wr = 1'b1; wd = 32'hFFFF_FFFF; tick();
        chk("R4 R2 mask all ones", rd, 32'h00FF_0000);

        // R12 + R2: tx-control strobe lands at bit 21
        sel = 1'b0; txc = 1'b1; tick();
        chk("R12 R2 tx-control bit", rd, 32'h0020_0000);
        chk("R5 irq on masked event", {31'd0, irq}, 32'd1);
        rxb = 1'b1; tick();
        chk("R12 R2 rx-buffer bit", rd, 32'h0021_0000);

        // R3: clear wins when no event; event wins over same-cycle clear
        wr = 1'b1; wd = 32'hFF20_FFFF; tick();
        chk("R3 write-one clears", rd, 32'h0001_0000);
        wr = 1'b1; wd = 32'h0001_0000; rxb = 1'b1; tick();
        chk("R3 set beats clear", rd, 32'h0001_0000);
        wr = 1'b1; wd = 32'h0000_0000; tick();
        chk("R3 write zero no effect", rd, 32'h0001_0000);
        wr = 1'b1; wd = 32'h00FF_0000; tick();

        // R6: stop during a frame waits for the frame end
        act = 1'b1; gstop = 1'b1; tick();
        tick(); tick();
        chk("R6 no stop before frame end", {rd[23], 30'd0, halt}, 32'h0);
        act = 1'b0; tick();
        chk("R6 stop done at frame end", {rd[23], 30'd0, halt}, 32'h8000_0001);
        tick(); tick();
        chk("R8 halt stays high", {31'd0, halt}, 32'd1);
        rstrt = 1'b1; tick();
        chk("R8 restart clears halt", {31'd0, halt}, 32'd0);

        // R7: idle stop is immediate
        wr = 1'b1; wd = 32'h0080_0000; tick();
        gstop = 1'b1; tick();
        chk("R7 idle stop immediate", {rd[23], 30'd0, halt}, 32'h8000_0001);
        rstrt = 1'b1; tick();

        // R8: restart cancels a waiting stop
        act = 1'b1; gstop = 1'b1; tick();
        rstrt = 1'b1; tick();
        act = 1'b0; tick();
        chk("R8 cancelled stop stays off", {31'd0, halt}, 32'd0);

        // R9: control frame ignored without flow control
        wr = 1'b1; wd = 32'h00FF_0000; tick();
        fc = 1'b0; rxc = 1'b1; tick();
        chk("R9 no rx-control bit", {31'd0, rd[22]}, 32'd0);
        chk("R9 no pause", {31'd0, pause}, 32'd0);
        tick();
        chk("R9 no later pause", {31'd0, pause}, 32'd0);

        // R10/R11: two control frames during a frame give one pulse at the end
        fc = 1'b1; act = 1'b1; rxc = 1'b1; tick();
        tick(); rxc = 1'b1; tick();
        chk("R9 rx-control recorded", {31'd0, rd[22]}, 32'd1);
        pulses = 0;
        act = 1'b0;
        for (int k = 0; k < 5; k++) begin
            tick();
            if (pause) pulses++;
        end
        chk("R11 single pause pulse", pulses, 32'd1);
        rxc = 1'b1; tick();
        chk("R10 idle pause immediate", {31'd0, pause}, 32'd1);
        tick();
        chk("R10 pause one cycle", {31'd0, pause}, 32'd0);

        // random phase, every cycle compared to the reference
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(7) == 0) act = ~act;
            if ($urandom_range(49) == 0) fc = ~fc;
            sel   = $urandom_range(1);
            gstop = ($urandom_range(31) == 0);
            rstrt = ($urandom_range(39) == 0);
            rxc   = ($urandom_range(9) == 0);
            txc   = ($urandom_range(7) == 0);
            txe   = ($urandom_range(7) == 0);
            rxf   = ($urandom_range(7) == 0);
            bsy   = ($urandom_range(7) == 0);
            txb   = ($urandom_range(7) == 0);
            rxb   = ($urandom_range(7) == 0);
            wr    = ($urandom_range(5) == 0);
            wd    = $urandom;
            tick();
        end
        summary();
    end

endmodule